// File: doc/BRIEF.md
# Binary64 to Binary32 Narrowing Converter

This unit narrows one IEEE-754 double-precision operand to a single-precision result. The 64-bit operand arrives as a pair of 32-bit register words that the caller concatenates. The caller also supplies an instruction opcode and a 2-bit rounding mode. The opcode arrives either in a 7-bit short form or in a 10-bit extended form. The extended value that selects the unit depends on a core-generation select pin. Beats whose opcode does not select the unit are consumed and produce nothing.

The unit has one register stage. An accepted, selected beat shows up as an output beat on the next cycle. Both edges use valid/ready. The input is ready whenever the output register is empty or is being drained in the same cycle. While the consumer holds the output back, the result and its valid are frozen and no new beat enters.

The datapath covers the following cases:
- exponent rebiasing;
- denormal alignment with a sticky bit;
- mode-directed rounding, including carries into the exponent;
- saturation on overflow, to infinity or to the largest finite value depending on the mode;
- NaN quieting.

Top module: `f64_to_f32_cvt`

## Requirements
- R1: In short form (`in_ext`=0) the unit is selected only when the whole 10-bit `in_opcode` equals 15.
- R2: In extended form (`in_ext`=1) the selecting opcode is 399 when `in_gen3`=0 and 335 when `in_gen3`=1. The other value of the pair does not select.
- R3: When an input beat is taken (`in_valid` and `in_ready`) and selects the unit, `out_valid` is high in the next cycle. A beat that does not select the unit is taken and never yields an output beat.
- R4: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_result` stays unchanged. After reset, `out_valid` is 0.
- R5: Mode 0 rounds to nearest with ties to even. This includes a round-up that carries from the mantissa into the exponent.
- R6: Mode 1 rounds toward +infinity, mode 2 toward -infinity, and mode 3 toward zero. Each decision depends on the sign and on whether any discarded bit is nonzero.
- R7: A magnitude too large for binary32 gives infinity (0x7F800000 plus sign) in mode 0, and in modes 1 and 2 when rounding points away from zero. In mode 3, and in modes 1 and 2 when rounding points toward zero, it gives the largest finite value (0x7F7FFFFF plus sign).
- R8: Magnitudes below the binary32 normal range give correctly rounded denormals or signed zero. Binary64 denormal inputs are included, and rounding may lift a result to the smallest normal 0x00800000.
- R9: A NaN input gives exponent 0xFF, quiet bit 22 set, bits 21..0 equal to input mantissa bits 50..29, and the input sign. An infinite input gives infinity of the same sign.
- R10: Bit 31 of the result always equals bit 63 of the operand. This includes zeros, overflow and NaN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Unit can take an input beat this cycle |
| in_ext | input | 1 | 1 = extended opcode form, 0 = short form |
| in_gen3 | input | 1 | Generation select for the extended opcode value |
| in_opcode | input | 10 | Opcode (short form uses values below 128) |
| in_operand | input | 64 | Binary64 operand, high word in bits 63..32 |
| in_rmode | input | 2 | Rounding mode: 0 nearest-even, 1 up, 2 down, 3 toward zero |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Consumer takes the result beat this cycle |
| out_result | output | 32 | Binary32 result |

## Verification
The hardest cases to reach are exact ties and round-ups that ripple all 23 mantissa bits into the exponent. These are rare in random binary64 operands, and the last of them runs into the infinity boundary. The bench therefore builds each operand from a chosen binary32 value plus a chosen 29-bit discarded tail. The tails it uses are zero, exactly half, just below half, just above half, and random. The expected result is then the chosen value or its bit-increment, decided from the mode, the sign and the tail. The denormal, binary64-denormal and NaN-payload cases are covered with worked vectors in every mode that changes the outcome.

// File: rtl/cvt_pkg.sv
package cvt_pkg;
  localparam int F64_EXP_W  = 11;
  localparam int F64_MAN_W  = 52;
  localparam int F32_EXP_W  = 8;
  localparam int F32_MAN_W  = 23;
  localparam int F64_W      = 1 + F64_EXP_W + F64_MAN_W;
  localparam int F32_W      = 1 + F32_EXP_W + F32_MAN_W;
  localparam int BIAS_DIFF  = 1023 - 127;
  localparam int DROP_W     = F64_MAN_W - F32_MAN_W;

  typedef enum logic [1:0] {
    RM_NEAR = 2'd0,
    RM_UP   = 2'd1,
    RM_DOWN = 2'd2,
    RM_ZERO = 2'd3
  } rmode_e;
endpackage

// File: rtl/cvt_op_match.sv
module cvt_op_match #(
  parameter int OPC_W       = 10,
  parameter int OPC_SHORT   = 15,
  parameter int OPC_EXT_OLD = 399,
  parameter int OPC_EXT_NEW = 335
) (
  input  logic             is_ext,
  input  logic             gen3,
  input  logic [OPC_W-1:0] opcode,
  output logic             hit
);
  localparam logic [OPC_W-1:0] SHORT_V = OPC_W'(OPC_SHORT);
  localparam logic [OPC_W-1:0] OLD_V   = OPC_W'(OPC_EXT_OLD);
  localparam logic [OPC_W-1:0] NEW_V   = OPC_W'(OPC_EXT_NEW);

  always_comb begin
    if (!is_ext)   hit = (opcode == SHORT_V);
    else if (gen3) hit = (opcode == NEW_V);
    else           hit = (opcode == OLD_V);
  end
endmodule

// File: rtl/cvt_narrow.sv
module cvt_narrow
  import cvt_pkg::*;
(
  input  logic [F64_W-1:0] operand,
  input  logic [1:0]       rmode,
  output logic [F32_W-1:0] result
);
  localparam int SIG_W = F64_MAN_W + 1;
  localparam int KEEP_W = F32_MAN_W + 1;

  logic                  sgn;
  logic [F64_EXP_W-1:0]  ex;
  logic [F64_MAN_W-1:0]  mn;
  logic                  is_top, is_low;
  logic signed [12:0]    be, need;
  logic [5:0]            sh;
  logic [SIG_W-1:0]      sig, shd;
  logic [KEEP_W-1:0]     kept;
  logic                  guard, sticky, lost, inc, big, ovf, to_inf;
  logic [KEEP_W:0]       sum;
  logic [F32_EXP_W-1:0]  ebase;
  logic [F32_W-2:0]      mag;
  rmode_e                rm;

  assign sgn    = operand[F64_W-1];
  assign ex     = operand[F64_W-2 -: F64_EXP_W];
  assign mn     = operand[F64_MAN_W-1:0];
  assign is_top = (ex == '1);
  assign is_low = (ex == '0);
  assign rm     = rmode_e'(rmode);

  // Alignment: target exponent and right shift for the denormal range.
  always_comb begin
    be   = $signed({2'b00, ex}) - 13'sd896;
    need = 13'sd1 - be;
    if (is_low)              sh = 6'd63;
    else if (be >= 13'sd1)   sh = 6'd0;
    else if (need > 13'sd63) sh = 6'd63;
    else                     sh = need[5:0];
  end

  assign sig    = {~is_low, mn};
  assign shd    = sig >> sh;
  assign lost   = ((shd << sh) != sig);
  assign kept   = shd[SIG_W-1 -: KEEP_W];
  assign guard  = shd[DROP_W-1];
  assign sticky = (|shd[DROP_W-2:0]) | lost;

  // Rounding decision per mode.
  always_comb begin
    unique case (rm)
      RM_NEAR: inc = guard & (sticky | kept[0]);
      RM_UP:   inc = ~sgn & (guard | sticky);
      RM_DOWN: inc = sgn & (guard | sticky);
      default: inc = 1'b0;
    endcase
  end

  assign sum   = {1'b0, kept} + {{KEEP_W{1'b0}}, inc};
  assign big   = ~is_low & (be > 13'sd254);
  assign ebase = (sh == 6'd0) ? F32_EXP_W'(be - 13'sd1) : '0;
  // The hidden bit in sum adds one to the exponent field; a carry adds another.
  assign mag   = {ebase, {F32_MAN_W{1'b0}}} + (F32_W-1)'(sum);
  assign ovf   = big | (mag[F32_W-2 -: F32_EXP_W] == '1);
  assign to_inf = (rm == RM_NEAR) | ((rm == RM_UP) & ~sgn) | ((rm == RM_DOWN) & sgn);

  always_comb begin
    if (is_top) begin
      if (mn != '0) result = {sgn, 8'hff, 1'b1, mn[F64_MAN_W-2 -: F32_MAN_W-1]};
      else          result = {sgn, 8'hff, {F32_MAN_W{1'b0}}};
    end else if (ovf) begin
      result = to_inf ? {sgn, 31'h7f80_0000} : {sgn, 31'h7f7f_ffff};
    end else begin
      result = {sgn, mag};
    end
  end
endmodule

// File: rtl/cvt_out_reg.sv
module cvt_out_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic         can_take,
  output logic         vld,
  input  logic         rdy,
  output logic [W-1:0] dout
);
  assign can_take = ~vld | rdy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld  <= 1'b0;
      dout <= '0;
    end else if (can_take) begin
      vld <= load;
      if (load) dout <= din;
    end
  end
endmodule

// File: rtl/f64_to_f32_cvt.sv
module f64_to_f32_cvt
  import cvt_pkg::*;
#(
  parameter int OPC_W       = 10,
  parameter int OPC_SHORT   = 15,
  parameter int OPC_EXT_OLD = 399,
  parameter int OPC_EXT_NEW = 335
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_ext,
  input  logic             in_gen3,
  input  logic [OPC_W-1:0] in_opcode,
  input  logic [63:0]      in_operand,
  input  logic [1:0]       in_rmode,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [31:0]      out_result
);
  logic             op_hit;
  logic [F32_W-1:0] narrow_res;

  cvt_op_match #(
    .OPC_W(OPC_W), .OPC_SHORT(OPC_SHORT),
    .OPC_EXT_OLD(OPC_EXT_OLD), .OPC_EXT_NEW(OPC_EXT_NEW)
  ) u_match (
    .is_ext(in_ext), .gen3(in_gen3), .opcode(in_opcode), .hit(op_hit)
  );

  cvt_narrow u_narrow (
    .operand(in_operand), .rmode(in_rmode), .result(narrow_res)
  );

  cvt_out_reg #(.W(F32_W)) u_out (
    .clk(clk), .rst_n(rst_n),
    .load(in_valid & op_hit), .din(narrow_res),
    .can_take(in_ready), .vld(out_valid),
    .rdy(out_ready), .dout(out_result)
  );
endmodule

// File: rtl/cvt_checker.sv
module cvt_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        hit,
  input logic [63:0] in_operand,
  input logic [1:0]  in_rmode,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_result
);
  p_take_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && hit) |=> out_valid);

  p_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !hit) |=> !out_valid);

  p_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result)));

  p_inf_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && hit && in_operand[62:52] > 11'd1150 &&
     in_operand[62:52] != 11'h7ff && in_rmode == 2'd0)
    |=> out_result[30:0] == 31'h7f80_0000);

  p_tiny_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && hit && in_operand[62:52] < 11'd850 && in_rmode == 2'd3)
    |=> out_result[30:0] == 31'h0);

  p_nan_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && hit && in_operand[62:52] == 11'h7ff && in_operand[51:0] != 52'h0)
    |=> out_result[30:22] == 9'h1ff);

  p_sign_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && hit) |=> out_result[31] == $past(in_operand[63]));
endmodule

bind f64_to_f32_cvt cvt_checker u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .hit(op_hit), .in_operand(in_operand), .in_rmode(in_rmode),
  .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result)
);

// File: tb/f64_to_f32_cvt_bench.sv
module f64_to_f32_cvt_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_ext = 1'b0;
  logic        in_gen3 = 1'b0;
  logic [9:0]  in_opcode = '0;
  logic [63:0] in_operand = '0;
  logic [1:0]  in_rmode = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_result;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  f64_to_f32_cvt u_f64_to_f32_cvt (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_ext(in_ext), .in_gen3(in_gen3), .in_opcode(in_opcode),
    .in_operand(in_operand), .in_rmode(in_rmode), .out_valid(out_valid),
    .out_ready(out_ready), .out_result(out_result)
  );

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      summary();
      $finish;
    end
  end

  // Monitor: pop and compare on every output transfer.
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3 unexpected output", {32'h0, out_result}, 64'h0);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(out_result == e, t, {32'h0, out_result}, {32'h0, e});
      end
    end
  end

  task automatic send(input logic ext, input logic g3, input logic [9:0] opc,
                      input logic [63:0] x, input logic [1:0] rm,
                      input logic hit, input logic [31:0] expv, input string tag);
    logic acc;
    @(posedge clk); #2;
    in_valid = 1'b1; in_ext = ext; in_gen3 = g3; in_opcode = opc;
    in_operand = x; in_rmode = rm;
    acc = 1'b0;
    while (!acc) begin
      @(negedge clk); acc = in_ready;
      @(posedge clk); #2;
    end
    if (hit) begin exp_q.push_back(expv); tag_q.push_back(tag); end
    in_valid = 1'b0;
    @(negedge clk);
    if (out_ready) chk(out_valid == hit, "R3 valid one cycle after take", {63'h0, out_valid}, {63'h0, hit});
  endtask

  task automatic cvt(input logic [63:0] x, input logic [1:0] rm, input logic [31:0] expv, input string tag);
    send(1'b0, 1'b0, 10'd15, x, rm, 1'b1, expv, tag);
  endtask

  // Independent model: binary32 value y plus a 29-bit discarded tail p.
  function automatic logic [31:0] step_ref(input logic [31:0] y, input logic [28:0] p, input logic [1:0] rm);
    logic up;
    case (rm)
      2'd0: up = (p > 29'h1000_0000) || (p == 29'h1000_0000 && y[0]);
      2'd1: up = !y[31] && p != 0;
      2'd2: up = y[31] && p != 0;
      default: up = 1'b0;
    endcase
    return up ? y + 32'd1 : y;
  endfunction

  function automatic logic [63:0] widen(input logic [31:0] y, input logic [28:0] p);
    return {y[31], 11'(y[30:23]) + 11'd896, y[22:0], p};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R4 reset out_valid", {63'h0, out_valid}, 64'h0);
    chk(in_ready == 1'b1, "R4 reset in_ready", {63'h0, in_ready}, 64'h1);
    rst_n = 1'b1;

    // R1 / R2: opcode selection
    cvt(64'h3ff0_0000_0000_0000, 2'd0, 32'h3f80_0000, "R1 short opcode 15, 1.0");
    send(1'b0, 1'b0, 10'd16, 64'h3ff0_0000_0000_0000, 2'd0, 1'b0, 0, "R1 short 16 rejected");
    send(1'b0, 1'b0, 10'h08f, 64'h3ff0_0000_0000_0000, 2'd0, 1'b0, 0, "R1 upper bits rejected");
    send(1'b1, 1'b0, 10'd399, 64'hc000_0000_0000_0000, 2'd0, 1'b1, 32'hc000_0000, "R2 ext 399 gen<3");
    send(1'b1, 1'b1, 10'd399, 64'hc000_0000_0000_0000, 2'd0, 1'b0, 0, "R2 ext 399 gen3 rejected");
    send(1'b1, 1'b1, 10'd335, 64'h4008_0000_0000_0000, 2'd0, 1'b1, 32'h4040_0000, "R2 ext 335 gen3");
    send(1'b1, 1'b0, 10'd335, 64'h4008_0000_0000_0000, 2'd0, 1'b0, 0, "R2 ext 335 gen<3 rejected");

    // R5 / R6: rounding at chosen tails, all modes
    for (int i = 0; i < 120; i++) begin
      logic [31:0] y;
      logic [28:0] p;
      logic [1:0]  rm;
      y = {1'($urandom), 8'(1 + ($urandom % 254)), 23'($urandom)};
      if (i % 10 == 0) y[22:0] = '1;
      if (i % 20 == 0) y[30:23] = 8'd200;
      case (i % 5)
        0: p = 29'h0;
        1: p = 29'h1000_0000;
        2: p = 29'h0fff_ffff;
        3: p = 29'h1000_0001;
        default: p = 29'($urandom);
      endcase
      rm = 2'(i % 4);
      cvt(widen(y, p), rm, step_ref(y, p, rm), rm == 0 ? "R5 nearest-even" : "R6 directed");
    end
    cvt(widen(32'h3f80_0001, 29'h1000_0000), 2'd0, 32'h3f80_0002, "R5 tie odd rounds up");
    cvt(widen(32'h3f80_0000, 29'h1000_0000), 2'd0, 32'h3f80_0000, "R5 tie even stays");
    cvt(widen(32'h3fff_ffff, 29'h1000_0000), 2'd0, 32'h4000_0000, "R5 carry into exponent");
    cvt(widen(32'hbf80_0000, 29'h1), 2'd2, 32'hbf80_0001, "R6 down negative");
    cvt(widen(32'hbf80_0000, 29'h1), 2'd1, 32'hbf80_0000, "R6 up negative");
    cvt(widen(32'h3f80_0000, 29'h1fff_ffff), 2'd3, 32'h3f80_0000, "R6 toward zero");

    // R7: overflow
    cvt(64'h47f0_0000_0000_0000, 2'd0, 32'h7f80_0000, "R7 nearest inf");
    cvt(64'h47f0_0000_0000_0000, 2'd3, 32'h7f7f_ffff, "R7 zero max");
    cvt(64'h47f0_0000_0000_0000, 2'd2, 32'h7f7f_ffff, "R7 down positive max");
    cvt(64'h47f0_0000_0000_0000, 2'd1, 32'h7f80_0000, "R7 up positive inf");
    cvt(64'hc7f0_0000_0000_0000, 2'd1, 32'hff7f_ffff, "R7 up negative max");
    cvt(64'hc7f0_0000_0000_0000, 2'd2, 32'hff80_0000, "R7 down negative inf");
    cvt(widen(32'h7f7f_ffff, 29'h1000_0000), 2'd0, 32'h7f80_0000, "R7 round to inf");

    // R8: underflow
    cvt(64'h36a0_0000_0000_0000, 2'd0, 32'h0000_0001, "R8 min denormal");
    cvt(64'h3690_0000_0000_0000, 2'd0, 32'h0000_0000, "R8 half min tie to zero");
    cvt(64'h3690_0000_0000_0000, 2'd1, 32'h0000_0001, "R8 half min up");
    cvt(64'h3698_0000_0000_0000, 2'd0, 32'h0000_0001, "R8 above half rounds up");
    cvt(64'h380f_ffff_ffff_ffff, 2'd0, 32'h0080_0000, "R8 round to min normal");
    cvt(64'h380f_ffff_ffff_ffff, 2'd3, 32'h007f_ffff, "R8 max denormal");
    cvt(64'h0000_0000_0000_0001, 2'd1, 32'h0000_0001, "R8 f64 denormal up");
    cvt(64'h0000_0000_0000_0001, 2'd0, 32'h0000_0000, "R8 f64 denormal nearest");
    cvt(64'h8000_0000_0000_0001, 2'd2, 32'h8000_0001, "R8 f64 denormal down negative");

    // R9 / R10: special values and sign
    cvt(64'h7ff8_0000_0000_0001, 2'd0, 32'h7fc0_0000, "R9 quiet NaN");
    cvt(64'hfff0_0000_2000_0000, 2'd3, 32'hffc0_0001, "R9 signaling NaN payload");
    cvt(64'hfff0_0000_0000_0000, 2'd3, 32'hff80_0000, "R9 negative infinity");
    cvt(64'h8000_0000_0000_0000, 2'd0, 32'h8000_0000, "R10 negative zero");
    cvt(64'hb690_0000_0000_0000, 2'd0, 32'h8000_0000, "R10 negative underflow zero");

    // R4: back-pressure
    @(posedge clk); #2;
    out_ready = 1'b0;
    send(1'b0, 1'b0, 10'd15, 64'h4000_0000_0000_0000, 2'd0, 1'b1, 32'h4000_0000, "R4 held beat A");
    @(posedge clk); #2;
    in_valid = 1'b1; in_ext = 1'b0; in_opcode = 10'd15;
    in_operand = 64'h4010_0000_0000_0000; in_rmode = 2'd0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(in_ready == 1'b0, "R4 in_ready low while stalled", {63'h0, in_ready}, 64'h0);
      chk(out_valid && out_result == 32'h4000_0000, "R4 result held", {32'h0, out_result}, 64'h4000_0000);
    end
    exp_q.push_back(32'h4080_0000); tag_q.push_back("R4 beat B after release");
    @(posedge clk); #2;
    out_ready = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R4 in_ready with out_ready", {63'h0, in_ready}, 64'h1);
    @(posedge clk); #2;
    in_valid = 1'b0;
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R3 all expected beats seen", 64'(exp_q.size()), 64'h0);
    summary();
    $finish;
  end
endmodule